// File: doc/BRIEF.md
# Transfer Unit Fill Scheduler

This block paces video data onto a packetized link. The link carries data in fixed-size transfer units. Each unit holds a number of slots, and each slot carries either a video byte or a stuffing symbol. For every unit the scheduler decides how many slots carry data. That count is an integer minimum plus at most one extra slot. The extra slot comes from a 10-bit fractional accumulator, so over a line the average fill tracks the video-to-link bandwidth ratio.

A line begins with a `line_start` pulse. The scheduler first holds off for a programmable number of cycles so that the upstream byte buffer can fill. It then emits slots as a valid/ready stream. While `slot_valid` is high and `slot_ready` is low, the slot is held unchanged and nothing is pulled from the buffer. A slot is consumed only on a cycle with both signals high. On that cycle `buf_req` is raised when the slot carries data. The line closes after the programmed number of data slots. The unit in progress is padded out with stuffing, and `line_end` marks the last slot of the line.

Configuration is sampled on the accepted `line_start` pulse and stays fixed for the rest of the line.

Top module: `tu_fill_sched`

## Requirements
- R1: After reset, `slot_valid`, `slot_is_data`, `slot_is_stuff`, `line_end` and `buf_req` are low, and the block is idle and ready to accept `line_start`.
- R2: The effective unit size is `cfg_tu_size` with bit 0 forced to zero. For example, a value of 33 yields units of 32 slots.
- R3: Within a unit, slot indices 0 to F-1 are data and the rest, up to the unit size, are stuffing, where F is that unit's fill. `slot_is_stuff` is the complement of `slot_is_data` whenever `slot_valid` is high.
- R4: Fill F of unit k is `cfg_min_bytes` plus c_k. The accumulator starts at 0 and c_0 = 0. After each unit, `cfg_frac` is added to the 10-bit accumulator, and the carry-out of that sum is c for the next unit.
- R5: The accumulator is cleared for every accepted line, so two lines with equal configuration produce identical slot sequences.
- R6: After the edge that accepts `line_start`, exactly `cfg_init_wait` cycles pass with `slot_valid` low. With a wait of 0, the first slot is valid in the very next cycle.
- R7: `buf_req` is high only on a handshake (`slot_valid` and `slot_ready`) of a data slot. It is never high during the initial wait.
- R8: A line holds exactly `cfg_line_slots` data slots. After the last data slot, the unit in progress is completed with stuffing. `line_end` is high on the final slot of that unit, and after it the block returns to idle with `slot_valid` low. A count of 0 produces one unit of pure stuffing.
- R9: While `slot_valid` is high and `slot_ready` is low, `slot_valid`, `slot_is_data` and `line_end` remain stable and `buf_req` stays low.
- R10: `line_start` and changes to the configuration inputs are ignored while a line is in its wait or slot phase.
- R11: When `cfg_min_bytes` plus carry exceeds the unit size, the fill is clamped to the unit size and the unit is all data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tu_size | input | 7 | Transfer unit size in slots (bit 0 ignored) |
| cfg_min_bytes | input | 7 | Integer data slots per unit |
| cfg_frac | input | 10 | Fractional fill, scaled by 1024 |
| cfg_init_wait | input | 7 | Cycles of hold-off at line start |
| cfg_line_slots | input | 16 | Data slots per line |
| line_start | input | 1 | Pulse that starts a line when idle |
| slot_ready | input | 1 | Downstream accepts the current slot |
| slot_valid | output | 1 | A slot is presented |
| slot_is_data | output | 1 | Presented slot carries a video byte |
| slot_is_stuff | output | 1 | Presented slot is stuffing |
| line_end | output | 1 | Presented slot is the last of the line |
| buf_req | output | 1 | Pull one byte from the input buffer this cycle |

## Verification
The fill pattern is exercised with a zero fraction (every unit has the same fill) and with fractions of 512, 341, 700, 100 and 1000. These separate a correct carry schedule from one that is off by a unit or that never carries. Two identical lines in a row show whether the accumulator is cleared between lines. Odd unit sizes, an over-large minimum, a line that ends exactly on a unit boundary and an empty line probe the size masking, the clamp and the close-out logic. Random back-pressure and a `line_start` pulse with altered configuration issued mid-line show whether held slots stay stable and whether a running line can be disturbed.

// File: rtl/tu_fill_pkg.sv
package tu_fill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } sched_state_e;
endpackage

// File: rtl/tu_fill_acc.sv
// Fractional accumulator and per-unit fill register.
module tu_fill_acc #(
  parameter int TUW   = 7,
  parameter int FRACW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [TUW-1:0]   min_load,
  input  logic [TUW-1:0]   tu_load,
  input  logic [TUW-1:0]   min_run,
  input  logic [TUW-1:0]   tu_run,
  input  logic [FRACW-1:0] frac_run,
  output logic [TUW:0]     fill_o
);
  logic [FRACW-1:0] acc_q;
  logic [FRACW:0]   sum;
  logic [TUW:0]     fill_q;

  function automatic logic [TUW:0] clamp_fill(input logic [TUW-1:0] m,
                                              input logic c,
                                              input logic [TUW-1:0] t);
    logic [TUW:0] s;
    s = {1'b0, m} + {{TUW{1'b0}}, c};
    return (s > {1'b0, t}) ? {1'b0, t} : s;
  endfunction

  always_comb sum = {1'b0, acc_q} + {1'b0, frac_run};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      fill_q <= '0;
    end else if (clear) begin
      acc_q  <= '0;
      fill_q <= clamp_fill(min_load, 1'b0, tu_load);
    end else if (advance) begin
      acc_q  <= sum[FRACW-1:0];
      fill_q <= clamp_fill(min_run, sum[FRACW], tu_run);
    end
  end

  assign fill_o = fill_q;

  // R4
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !clear && ({1'b0, min_run} < {1'b0, tu_run})
    |=> (fill_q == {1'b0, $past(min_run)}) ||
        (fill_q == {1'b0, $past(min_run)} + 1'b1));
endmodule

// File: rtl/tu_fill_wait.sv
// Per-line start-up hold-off counter.
module tu_fill_wait #(
  parameter int TUW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [TUW-1:0] len,
  output logic           busy,
  output logic           expire
);
  logic [TUW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= len;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy   = (cnt_q != '0);
  assign expire = (cnt_q == TUW'(1));

  // R6
  wait_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/tu_fill_slots.sv
// Slot index within a unit and remaining data slots in the line.
module tu_fill_slots #(
  parameter int TUW   = 7,
  parameter int LINEW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             is_data,
  input  logic [LINEW-1:0] count_load,
  input  logic [TUW-1:0]   tu_run,
  output logic [TUW-1:0]   idx_o,
  output logic [LINEW-1:0] left_o,
  output logic             tu_last_o
);
  logic [TUW-1:0]   idx_q;
  logic [LINEW-1:0] left_q;

  assign tu_last_o = (idx_q == tu_run - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      left_q <= '0;
    end else if (load) begin
      idx_q  <= '0;
      left_q <= count_load;
    end else if (step) begin
      idx_q  <= tu_last_o ? '0 : idx_q + 1'b1;
      left_q <= left_q - LINEW'(is_data);
    end
  end

  assign idx_o  = idx_q;
  assign left_o = left_q;

  // R8
  left_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> left_q <= $past(left_q));
endmodule

// File: rtl/tu_fill_sched.sv
module tu_fill_sched
  import tu_fill_pkg::*;
#(
  parameter int TU_W     = 7,
  parameter int FRAC_W   = 10,
  parameter int LINE_W   = 16,
  parameter int TU_RESET = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TU_W-1:0]   cfg_tu_size,
  input  logic [TU_W-1:0]   cfg_min_bytes,
  input  logic [FRAC_W-1:0] cfg_frac,
  input  logic [TU_W-1:0]   cfg_init_wait,
  input  logic [LINE_W-1:0] cfg_line_slots,
  input  logic              line_start,
  input  logic              slot_ready,
  output logic              slot_valid,
  output logic              slot_is_data,
  output logic              slot_is_stuff,
  output logic              line_end,
  output logic              buf_req
);
  sched_state_e      state_q, state_d;
  logic [TU_W-1:0]   tu_q, min_q;
  logic [FRAC_W-1:0] frac_q;
  logic [TU_W-1:0]   tu_in;
  logic              accept, fire;
  logic              wait_busy, wait_expire;
  logic [TU_W:0]     fill;
  logic [TU_W-1:0]   idx;
  logic [LINE_W-1:0] left, left_after;
  logic              tu_last;

  assign tu_in  = cfg_tu_size & ~TU_W'(1);
  assign accept = (state_q == ST_IDLE) && line_start;

  assign slot_valid    = (state_q == ST_RUN);
  assign slot_is_data  = slot_valid && ({1'b0, idx} < fill) && (left != '0);
  assign slot_is_stuff = slot_valid && !slot_is_data;
  assign left_after    = left - LINE_W'(slot_is_data);
  assign line_end      = slot_valid && tu_last && (left_after == '0);
  assign fire          = slot_valid && slot_ready;
  assign buf_req       = fire && slot_is_data;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = (cfg_init_wait == '0) ? ST_RUN : ST_WAIT;
      ST_WAIT: if (wait_expire) state_d = ST_RUN;
      ST_RUN:  if (fire && line_end) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tu_q    <= TU_W'(TU_RESET);
      min_q   <= '0;
      frac_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        tu_q   <= tu_in;
        min_q  <= cfg_min_bytes;
        frac_q <= cfg_frac;
      end
    end
  end

  tu_fill_acc #(.TUW(TU_W), .FRACW(FRAC_W)) acc_i (
    .clk(clk), .rst_n(rst_n),
    .clear(accept), .advance(fire && tu_last),
    .min_load(cfg_min_bytes), .tu_load(tu_in),
    .min_run(min_q), .tu_run(tu_q), .frac_run(frac_q),
    .fill_o(fill)
  );

  tu_fill_wait #(.TUW(TU_W)) wait_i (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .len(cfg_init_wait),
    .busy(wait_busy), .expire(wait_expire)
  );

  tu_fill_slots #(.TUW(TU_W), .LINEW(LINE_W)) slots_i (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .step(fire), .is_data(slot_is_data),
    .count_load(cfg_line_slots), .tu_run(tu_q),
    .idx_o(idx), .left_o(left), .tu_last_o(tu_last)
  );

  // R7
  no_req_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_busy |-> !slot_valid && !buf_req);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid && !slot_ready
    |=> slot_valid && $stable(slot_is_data) && $stable(line_end));

  // R3
  stuff_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !slot_is_data && !tu_last |=> !slot_is_data);

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid && !(fire && line_end) |=> slot_valid);
endmodule

// File: tb/tu_fill_sched_tb_top.sv
module tu_fill_sched_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  cfg_tu_size = 7'd64;
  logic [6:0]  cfg_min_bytes = '0;
  logic [9:0]  cfg_frac = '0;
  logic [6:0]  cfg_init_wait = '0;
  logic [15:0] cfg_line_slots = '0;
  logic        line_start = 1'b0;
  logic        slot_ready = 1'b1;
  logic        slot_valid, slot_is_data, slot_is_stuff, line_end, buf_req;

  always #5 clk = ~clk;

  tu_fill_sched dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_tu_size(cfg_tu_size), .cfg_min_bytes(cfg_min_bytes),
    .cfg_frac(cfg_frac), .cfg_init_wait(cfg_init_wait),
    .cfg_line_slots(cfg_line_slots), .line_start(line_start),
    .slot_ready(slot_ready), .slot_valid(slot_valid),
    .slot_is_data(slot_is_data), .slot_is_stuff(slot_is_stuff),
    .line_end(line_end), .buf_req(buf_req)
  );

  typedef struct packed { logic data; logic last; } exp_t;
  exp_t exp_q[$];
  int   checks = 0;
  int   fails = 0;
  int   cyc = 0;
  bit   line_done = 0;
  bit   bp_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ready generator (updates at posedge, stable at negedge)
  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    slot_ready <= bp_mode ? lfsr[0] : 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  // monitor / scoreboard
  bit   stalled = 0;
  logic held_data, held_end;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled) begin
        chk(slot_valid == 1'b1, "R9", "valid held", slot_valid, 1);
        chk(slot_is_data == held_data, "R9", "data held", slot_is_data, held_data);
        chk(line_end == held_end, "R9", "end held", line_end, held_end);
      end
      if (slot_valid && !slot_ready) begin
        chk(buf_req == 1'b0, "R9", "buf_req in stall", buf_req, 0);
        stalled = 1;
        held_data = slot_is_data;
        held_end = line_end;
      end else stalled = 0;
      if (slot_valid && slot_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8", "unexpected slot", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(slot_is_data == e.data, "R3", "slot_is_data", slot_is_data, e.data);
          chk(slot_is_stuff == !e.data, "R3", "slot_is_stuff", slot_is_stuff, !e.data);
          chk(line_end == e.last, "R8", "line_end", line_end, e.last);
          chk(buf_req == e.data, "R7", "buf_req", buf_req, e.data);
          if (line_end) line_done = 1;
        end
      end
    end
  end

  // reference model of one line: R2 mask, R4 carry, R11 clamp, R8 close-out
  task automatic build(input int tu_raw, input int mn, input int fr, input int n);
    int tu, acc, c, left, fill, s;
    bit done;
    exp_t e;
    tu = tu_raw & 'h7E;
    acc = 0; c = 0; left = n; done = 0;
    while (!done) begin
      fill = mn + c;
      if (fill > tu) fill = tu;
      for (int i = 0; i < tu; i++) begin
        e.data = (i < fill) && (left > 0);
        if (e.data) left--;
        e.last = (i == tu - 1) && (left == 0);
        exp_q.push_back(e);
      end
      if (left == 0) done = 1;
      s = acc + fr;
      c = s >> 10;
      acc = s & 1023;
    end
  endtask

  task automatic run_line(input int tu, input int mn, input int fr,
                          input int w, input int n, input bit poke);
    int idle;
    cfg_tu_size = 7'(tu); cfg_min_bytes = 7'(mn); cfg_frac = 10'(fr);
    cfg_init_wait = 7'(w); cfg_line_slots = 16'(n);
    build(tu, mn, fr, n);
    line_done = 0;
    @(negedge clk); line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    idle = 0;
    while (!slot_valid && idle < 200) begin
      chk(buf_req == 1'b0, "R7", "buf_req during wait", buf_req, 0);
      idle++;
      @(negedge clk);
    end
    chk(idle == w, "R6", "wait cycles", idle, w);
    if (poke) begin
      // R10: restart attempt with other config mid-line
      cfg_tu_size = 7'd32; cfg_min_bytes = 7'd3; cfg_frac = 10'd999;
      cfg_init_wait = 7'd0; cfg_line_slots = 16'd5;
      line_start = 1'b1;
      @(negedge clk); line_start = 1'b0;
    end
    while (!line_done) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "slots left over", exp_q.size(), 0);
    exp_q.delete();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(slot_valid == 1'b0, "R8", "idle after line", slot_valid, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(slot_valid == 0, "R1", "slot_valid", slot_valid, 0);
    chk(slot_is_data == 0 && slot_is_stuff == 0, "R1", "data/stuff",
        slot_is_data | slot_is_stuff, 0);
    chk(line_end == 0 && buf_req == 0, "R1", "end/req", line_end | buf_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(slot_valid == 0, "R1", "slot_valid after reset", slot_valid, 0);

    run_line(64, 40, 0, 0, 200, 0);      // R3, R6 zero wait
    run_line(64, 30, 512, 5, 300, 0);    // R4 carry every second unit
    run_line(32, 10, 341, 32, 100, 0);   // R5 first of two equal lines
    run_line(32, 10, 341, 32, 100, 0);   // R5 second line repeats
    run_line(33, 12, 0, 3, 80, 0);       // R2 odd size masked to 32
    bp_mode = 1;
    run_line(64, 20, 700, 7, 250, 0);    // R9 back-pressure
    bp_mode = 0;
    run_line(64, 70, 1000, 1, 150, 0);   // R11 clamp to unit size
    run_line(32, 16, 0, 2, 48, 0);       // R8 ends on unit boundary
    run_line(64, 25, 100, 4, 120, 1);    // R10 mid-line restart ignored
    run_line(32, 8, 0, 0, 0, 0);         // R8 empty line, one stuffed unit

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule